// File: doc/BRIEF.md
# Two-Wire DAC Write Master

This block is a bus master that writes one value into one output register of an eight-channel, two-wire serial DAC. A host presents a 2-bit device address, a register-reset flag, a power-down flag, a 3-bit channel number and an 8-bit value, then pulses `req`. The block latches these fields and drives a complete write on the bus: a start condition, three bytes sent most significant bit first, an acknowledge clock after each byte, and a stop condition. SCL is a plain output. SDA is open-drain: `sda_oe` high pulls the line low and `sda_oe` low releases it. `sda_in` reads the resolved line.

Every bus phase lasts a parameterized number of clock cycles, so the clock high time, clock low time, start hold and stop setup all meet their minimums. After each stop the block holds `busy` until both the bus-free time and the mandatory gap between writes have passed. A request made while `busy` is high is ignored. A successful write ends with a one-cycle `done`. If the DAC leaves any acknowledge bit high, the master stops the write at once and raises `nack_err` for one cycle instead.

Top module: `dac_write_master`

## Requirements
- R1: After reset and whenever `busy` is low, `scl` is high and `sda_oe` is low, so the bus is released.
- R2: Each write has exactly one start and one stop. The start is SDA falling while SCL stays high, and the stop is SDA rising while SCL stays high. SDA never changes while SCL is high at any other time.
- R3: The bytes go out in this order, each most significant bit first: the address byte `0,1,0,1,0,dev_addr[1],dev_addr[0],0`, then the command byte `0,0,0,rst_flag,pd_flag,chan[2],chan[1],chan[0]`, then `value`.
- R4: During the ninth SCL pulse after each byte, the master keeps `sda_oe` low.
- R5: Every SCL high period, every SCL low period inside a write, the start hold time (SDA fall to the first SCL fall) and the stop setup time (last SCL rise to SDA rise) each last at least `T_HALF` cycles.
- R6: After a stop, `busy` stays high for at least `max(T_GAP, T_BUF)` cycles. No new start appears within that many cycles of the previous stop.
- R7: If an acknowledge bit is sampled high, no further byte is sent. The master issues a stop, and `nack_err` is high for exactly one cycle, in the cycle where SDA rises for the stop. `done` stays low for that write.
- R8: After a fully acknowledged write, `done` is high for exactly one cycle, in the cycle where SDA rises for the stop.
- R9: A `req` pulse while `busy` is high starts no write. Input changes after acceptance do not alter the bytes being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request, accepted only when `busy` is low |
| dev_addr | input | 2 | Device address bits of the DAC |
| rst_flag | input | 1 | Command bit that clears the DAC registers |
| pd_flag | input | 1 | Command bit that selects power-down |
| chan | input | 3 | Target output channel |
| value | input | 8 | Data byte for the channel |
| sda_in | input | 1 | Resolved SDA line level |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| busy | output | 1 | High from acceptance until the inter-write gap ends |
| done | output | 1 | One-cycle pulse on a successful write |
| nack_err | output | 1 | One-cycle pulse on a missing acknowledge |

## Verification
The bench builds the block with `T_HALF=3`, `T_BUF=5` and `T_GAP=40`. With these values a full three-byte write plus its gap takes about three hundred cycles. This puts every timing minimum, the gap enforcement for back-to-back requests, and all three acknowledge failure points within a short run. A slave model measures each interval in cycles against these small limits, so one cycle too few in any phase is caught.

// File: rtl/dac_write_master.sv
module dac_write_master #(
  parameter int unsigned T_HALF = 1175,
  parameter int unsigned T_BUF  = 1175,
  parameter int unsigned T_GAP  = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] dev_addr,
  input  logic       rst_flag,
  input  logic       pd_flag,
  input  logic [2:0] chan,
  input  logic [7:0] value,
  input  logic       sda_in,
  output logic       scl,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       nack_err
);

  localparam int unsigned GAP_CYC = (T_GAP > T_BUF) ? T_GAP : T_BUF;
  localparam int unsigned CNT_MAX = (GAP_CYC > T_HALF) ? GAP_CYC : T_HALF;
  localparam int          CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_PLOW, ST_PHIGH, ST_GAP
  } st_t;

  st_t          state;
  logic [CW-1:0] cnt;
  logic [23:0]  frame;
  logic [3:0]   bitn;
  logic [1:0]   byten;
  logic         nack_q;
  logic         sda_next;

  wire tick = (cnt == CW'((state == ST_GAP) ? GAP_CYC : T_HALF));

  assign scl  = !(state == ST_LOW || state == ST_PLOW);
  assign busy = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START, ST_PLOW, ST_PHIGH: sda_next = 1'b1;
      ST_LOW, ST_HIGH:             sda_next = (bitn != 4'd8) && !frame[23];
      default:                     sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      frame    <= '0;
      bitn     <= '0;
      byten    <= '0;
      nack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      sda_oe   <= sda_next;
      done     <= (state == ST_GAP) && (cnt == '0) && !nack_q;
      nack_err <= (state == ST_GAP) && (cnt == '0) && nack_q;
      cnt      <= (state == ST_IDLE || tick) ? '0 : cnt + 1'b1;
      case (state)
        ST_IDLE:
          if (req) begin
            state  <= ST_START;
            frame  <= {5'b01010, dev_addr, 1'b0, 3'b000, rst_flag, pd_flag, chan, value};
            bitn   <= '0;
            byten  <= '0;
            nack_q <= 1'b0;
          end
        ST_START: if (tick) state <= ST_LOW;
        ST_LOW:   if (tick) state <= ST_HIGH;
        ST_HIGH:
          if (tick) begin
            if (bitn == 4'd8) begin
              bitn <= '0;
              if (sda_in) begin
                nack_q <= 1'b1;
                state  <= ST_PLOW;
              end else if (byten == 2'd2) begin
                state <= ST_PLOW;
              end else begin
                byten <= byten + 2'd1;
                state <= ST_LOW;
              end
            end else begin
              bitn  <= bitn + 4'd1;
              frame <= {frame[22:0], 1'b0};
              state <= ST_LOW;
            end
          end
        ST_PLOW:  if (tick) state <= ST_PHIGH;
        ST_PHIGH: if (tick) state <= ST_GAP;
        ST_GAP:   if (tick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && !sda_oe));

  assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && scl && $past(scl)) |-> ($past(state) == ST_START));

  assert_stop_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && scl && $past(scl)) |-> ($past(state, 2) == ST_PHIGH));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && bitn == 4'd8) |-> !sda_oe);

  assert_nack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |-> (!done && scl && !sda_oe) ##1 !nack_err);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl && !sda_oe) ##1 !done);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req) && !$past(busy)));

endmodule

// File: tb/dac_write_master_tb_top.sv
module dac_write_master_tb_top;
  localparam int TH = 3;
  localparam int TB = 5;
  localparam int TG = 40;

  // vector: [16:15] dev, [14] rst, [13] pd, [12:10] chan, [9:2] value, [1:0] nacked byte (0 none)
  localparam logic [16:0] VEC [7] = '{
    {2'b01, 1'b0, 1'b0, 3'd0, 8'h00, 2'd0},
    {2'b10, 1'b1, 1'b0, 3'd7, 8'hFF, 2'd0},
    {2'b11, 1'b0, 1'b1, 3'd5, 8'hA5, 2'd0},
    {2'b00, 1'b1, 1'b1, 3'd2, 8'h3C, 2'd0},
    {2'b01, 1'b0, 1'b0, 3'd1, 8'h80, 2'd1},
    {2'b10, 1'b0, 1'b0, 3'd3, 8'h5A, 2'd2},
    {2'b11, 1'b1, 1'b0, 3'd6, 8'h01, 2'd3}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, req = 1'b0, rf = 1'b0, pf = 1'b0;
  logic [1:0] dev = '0;
  logic [2:0] ch = '0;
  logic [7:0] val = '0;
  logic scl, sda_oe, busy, done, nack_err;
  logic slv_pull = 1'b0;
  wire  sda_line = !(sda_oe || slv_pull);

  dac_write_master #(.T_HALF(TH), .T_BUF(TB), .T_GAP(TG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev), .rst_flag(rf),
    .pd_flag(pf), .chan(ch), .value(val), .sda_in(sda_line),
    .scl(scl), .sda_oe(sda_oe), .busy(busy), .done(done), .nack_err(nack_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rid, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
    end
  endtask

  // slave model and bus monitor
  logic prev_scl = 1'b1, prev_sda = 1'b1, s, in_frame = 1'b0, prev_done = 1'b0, prev_nack = 1'b0;
  logic [7:0] sh = '0;
  logic [7:0] got [4];
  int bitn = 0, nbytes = 0, starts = 0, stops = 0, nack_sel = 0;
  int t_rise = 0, t_fall = 0, t_stop = -100000;
  int viol_r4 = 0, viol_r5 = 0, viol_r6 = 0, viol_r7 = 0, viol_r8 = 0, done_cnt = 0, nack_cnt = 0;

  always @(negedge clk) if (rst_n) begin
    s = sda_line;
    if (scl && prev_scl && s != prev_sda) begin
      if (!s) begin
        starts++;
        if (cyc - t_stop < TG) viol_r6++;
        in_frame = 1'b1; bitn = 0; nbytes = 0; t_rise = cyc;
      end else begin
        stops++;
        if (cyc - t_rise < TH) viol_r5++;
        t_stop = cyc; in_frame = 1'b0;
      end
    end else if (scl && !prev_scl && in_frame) begin
      if (cyc - t_fall < TH) viol_r5++;
      t_rise = cyc;
      if (bitn < 8) begin
        sh = {sh[6:0], s}; bitn++;
      end else begin
        if (sda_oe) viol_r4++;
        if (nbytes < 4) got[nbytes] = sh;
        nbytes++; bitn = 9;
      end
    end else if (!scl && prev_scl && in_frame) begin
      if (cyc - t_rise < TH) viol_r5++;
      t_fall = cyc;
      if (bitn == 8) slv_pull = (nbytes + 1 != nack_sel);
      else if (bitn == 9) begin slv_pull = 1'b0; bitn = 0; end
    end
    if (done) begin done_cnt++; if (t_stop != cyc) viol_r8++; end
    if (nack_err) begin nack_cnt++; if (t_stop != cyc) viol_r7++; end
    if (done && prev_done) viol_r8++;
    if (nack_err && prev_nack) viol_r7++;
    prev_done = done; prev_nack = nack_err;
    prev_scl = scl; prev_sda = s;
  end

  task automatic run_txn(input logic [16:0] v, input bit poke);
    int s0, p0, d0, n0, nb, bf, nk;
    logic [7:0] exp [3];
    nk = int'(v[1:0]);
    exp[0] = {5'b01010, v[16:15], 1'b0};
    exp[1] = {3'b000, v[14], v[13], v[12:10]};
    exp[2] = v[9:2];
    while (busy) @(negedge clk);
    s0 = starts; p0 = stops; d0 = done_cnt; n0 = nack_cnt;
    nack_sel = nk;
    dev = v[16:15]; rf = v[14]; pf = v[13]; ch = v[12:10]; val = v[9:2];
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      dev = ~dev; rf = ~rf; pf = ~pf; ch = ~ch; val = ~val;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (busy) @(negedge clk);
    bf = cyc;
    nb = (nk == 0) ? 3 : nk;
    chk(starts - s0 == 1, "R2 starts", starts - s0, 1);
    chk(stops - p0 == 1, "R2 stops", stops - p0, 1);
    chk(nbytes == nb, "R3/R7 byte count", nbytes, nb);
    for (int i = 0; i < nb; i++) chk(got[i] == exp[i], "R3 byte", int'(got[i]), int'(exp[i]));
    chk(done_cnt - d0 == ((nk == 0) ? 1 : 0), "R8 done pulses", done_cnt - d0, (nk == 0) ? 1 : 0);
    chk(nack_cnt - n0 == ((nk != 0) ? 1 : 0), "R7 nack pulses", nack_cnt - n0, (nk != 0) ? 1 : 0);
    chk(bf - t_stop >= TG, "R6 busy hold", bf - t_stop, TG);
    chk(scl && !sda_oe, "R1 released after write", int'({scl, sda_oe}), 2);
    if (poke) begin
      repeat (3 * TG) @(negedge clk);
      chk(starts - s0 == 1, "R9 ignored request", starts - s0, 1);
      chk(!busy, "R9 stays idle", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl == 1'b1, "R1 reset scl", int'(scl), 1);
    chk(sda_oe == 1'b0, "R1 reset sda", int'(sda_oe), 0);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(!done && !nack_err, "R8 reset flags", int'({done, nack_err}), 0);

    foreach (VEC[k]) run_txn(VEC[k], 1'b0);

    run_txn({2'b10, 1'b0, 1'b1, 3'd4, 8'h11, 2'd0}, 1'b1);
    run_txn({2'b00, 1'b0, 1'b0, 3'd0, 8'hC3, 2'd2}, 1'b0);

    chk(viol_r4 == 0, "R4 ack release", viol_r4, 0);
    chk(viol_r5 == 0, "R5 timing minimums", viol_r5, 0);
    chk(viol_r6 == 0, "R6 stop to start gap", viol_r6, 0);
    chk(viol_r7 == 0, "R7 nack pulse shape", viol_r7, 0);
    chk(viol_r8 == 0, "R8 done pulse shape", viol_r8, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule